// File: doc/BRIEF.md
# Emergency-Escalating Fixed Priority Arbiter

This block decides, once per clock, which requester a communications processor serves next. Three kinds of requester compete. The first kind is a group of system events: a reset request, a DMA bus error and a host command. The second is a bank of DMA emulation channels. The third is a set of peripheral channels, each with a receive line, a transmit line and an emergency flag. The peripheral channels are full-duplex serial channels plus a group of multichannel controllers. The block returns a registered one-hot grant, the encoded index of the winner, a valid bit, and a bit that says whether the win came through the emergency tier.

The order is fixed, with two exceptions. First, a peripheral request whose channel has its emergency flag raised moves up to an emergency tier above all normal traffic. Inside that tier the winner follows the normal order. Second, a configuration bit puts the DMA emulation slot either directly above or directly below the emergency tier. The block holds no lock: every cycle it arbitrates again from the current request lines.

Grant index encoding: 0 reset, 1 bus error, 2 host command, 3..3+N_DMA-1 DMA channels, then the peripheral slots in normal order. With the default parameters the slots are: 7 channel A rx, 8 channel A tx, 9 multichannel 0 rx, 10 multichannel 1 rx, 11 multichannel 0 tx, 12 multichannel 1 tx, 13 channel B rx, 14 channel B tx, 15 channel C rx, 16 channel C tx.

Top module: `emg_prio_arb`

## Requirements
- R1: After reset, and one cycle after any cycle with no request, gnt is all zeros, gnt_idx is 0, and gnt_valid and gnt_emerg are low.
- R2: A reset request (req_rst) wins over everything and yields gnt_idx 0.
- R3: A bus error (req_buserr) wins over every request except a reset request, and yields gnt_idx 1.
- R4: A host command (req_cmd) wins over all DMA and peripheral requests, and yields gnt_idx 2.
- R5: When dma_alt is 0, any DMA emulation request wins over all emergency and normal peripheral requests.
- R6: When dma_alt is 1, any emergency request wins over DMA requests, and DMA requests win over all normal peripheral requests.
- R7: Among DMA channels the lowest index wins; DMA channel k yields gnt_idx 3+k.
- R8: A peripheral request whose channel has its emergency flag set wins over every normal peripheral request, and the grant carries gnt_emerg=1.
- R9: Among simultaneous emergency requests, the winner is the one that ranks highest in the normal order.
- R10: The normal order, highest first, is: channel A rx, channel A tx; all multichannel rx by index; all multichannel tx by index; then the rx and tx pair of each remaining channel, by index. The indices are those of the encoding above.
- R11: An emergency flag on a channel with no active rx or tx request has no effect on the winner and leaves gnt_emerg low.
- R12: The grant appears exactly one cycle after the requests are sampled. It follows the current requests on every cycle, so a grant ends on the cycle after its request drops.
- R13: gnt is zero or one-hot, gnt_valid is high exactly when gnt is non-zero, and gnt_idx is the position of the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset request (command-register reset or soft reset) |
| req_buserr | input | 1 | DMA bus error event |
| req_cmd | input | 1 | Host command pending |
| dma_req | input | N_DMA | DMA emulation requests, bit k = channel k |
| dma_alt | input | 1 | 0: DMA slot above the emergency tier; 1: below it |
| ch_rx | input | N_CH | Full-duplex channel receive requests, bit 0 = channel A |
| ch_tx | input | N_CH | Full-duplex channel transmit requests |
| ch_emg | input | N_CH | Full-duplex channel emergency flags |
| mc_rx | input | N_MC | Multichannel receive requests |
| mc_tx | input | N_MC | Multichannel transmit requests |
| mc_emg | input | N_MC | Multichannel emergency flags |
| gnt | output | NSRC | Registered one-hot grant |
| gnt_idx | output | IDXW | Encoded winner index |
| gnt_valid | output | 1 | A grant is present |
| gnt_emerg | output | 1 | The grant was won through the emergency tier |

## Verification
The two functions that can fall in the same cycle are emergency promotion and the DMA slot choice. The bench drives a DMA request together with an emergency request and runs the same pattern once with each value of dma_alt. A DMA win with gnt_emerg low is expected under the default setting, and a peripheral win with gnt_emerg high under the alternate one. Further vectors pair an emergency on a low-ranked slot with a normal request on a high-ranked slot, and pair a flag on an idle channel with traffic elsewhere. The expected index and emergency bit are checked on the cycle after sampling.

// File: rtl/emg_arb_pkg.sv
package emg_arb_pkg;

    localparam int SYS_N = 3;

    typedef enum logic [2:0] {
        TIER_NONE,
        TIER_SYS,
        TIER_DMA,
        TIER_EMG,
        TIER_NORM
    } tier_e;

    // Normal-order slot of full-duplex channel c receive (channel 0 leads).
    function automatic int ch_rx_slot(input int c, input int n_mc);
        if (c == 0) return 0;
        return 2 + 2 * n_mc + 2 * (c - 1);
    endfunction

    function automatic int ch_tx_slot(input int c, input int n_mc);
        return ch_rx_slot(c, n_mc) + 1;
    endfunction

    function automatic int mc_rx_slot(input int m);
        return 2 + m;
    endfunction

    function automatic int mc_tx_slot(input int m, input int n_mc);
        return 2 + n_mc + m;
    endfunction

endpackage

// File: rtl/emg_prio_pick.sv
module emg_prio_pick #(
    parameter int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic [W-1:0]  oh,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Prefix OR chain: bit i is masked when any lower bit requests.
    logic [W-1:0] lower;

    assign lower[0] = 1'b0;
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign lower[i] = lower[i-1] | req[i-1];
    end

    assign oh  = req & ~lower;
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (oh[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/emg_tier_map.sv
module emg_tier_map
    import emg_arb_pkg::*;
#(
    parameter int N_CH = 3,
    parameter int N_MC = 2,
    localparam int N_NORM = 2 * (N_CH + N_MC)
) (
    input  logic [N_CH-1:0]   ch_rx,
    input  logic [N_CH-1:0]   ch_tx,
    input  logic [N_CH-1:0]   ch_emg,
    input  logic [N_MC-1:0]   mc_rx,
    input  logic [N_MC-1:0]   mc_tx,
    input  logic [N_MC-1:0]   mc_emg,
    output logic [N_NORM-1:0] norm_req,
    output logic [N_NORM-1:0] emg_req
);
    logic [N_NORM-1:0] flag;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign norm_req[ch_rx_slot(c, N_MC)] = ch_rx[c];
        assign norm_req[ch_tx_slot(c, N_MC)] = ch_tx[c];
        assign flag[ch_rx_slot(c, N_MC)]     = ch_emg[c];
        assign flag[ch_tx_slot(c, N_MC)]     = ch_emg[c];
    end

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        assign norm_req[mc_rx_slot(m)]       = mc_rx[m];
        assign norm_req[mc_tx_slot(m, N_MC)] = mc_tx[m];
        assign flag[mc_rx_slot(m)]           = mc_emg[m];
        assign flag[mc_tx_slot(m, N_MC)]     = mc_emg[m];
    end

    // A flag only promotes slots that actually request.
    assign emg_req = norm_req & flag;

endmodule

// File: rtl/emg_prio_arb.sv
module emg_prio_arb
    import emg_arb_pkg::*;
#(
    parameter int N_CH  = 3,
    parameter int N_MC  = 2,
    parameter int N_DMA = 4,
    localparam int N_NORM    = 2 * (N_CH + N_MC),
    localparam int DMA_BASE  = SYS_N,
    localparam int NORM_BASE = SYS_N + N_DMA,
    localparam int NSRC      = NORM_BASE + N_NORM,
    localparam int IDXW      = $clog2(NSRC),
    localparam int DIW       = (N_DMA > 1) ? $clog2(N_DMA) : 1,
    localparam int NIW       = (N_NORM > 1) ? $clog2(N_NORM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rst,
    input  logic              req_buserr,
    input  logic              req_cmd,
    input  logic [N_DMA-1:0]  dma_req,
    input  logic              dma_alt,
    input  logic [N_CH-1:0]   ch_rx,
    input  logic [N_CH-1:0]   ch_tx,
    input  logic [N_CH-1:0]   ch_emg,
    input  logic [N_MC-1:0]   mc_rx,
    input  logic [N_MC-1:0]   mc_tx,
    input  logic [N_MC-1:0]   mc_emg,
    output logic [NSRC-1:0]   gnt,
    output logic [IDXW-1:0]   gnt_idx,
    output logic              gnt_valid,
    output logic              gnt_emerg
);

    typedef struct packed {
        logic [NSRC-1:0] gnt;
        logic [IDXW-1:0] idx;
        logic            valid;
        logic            emerg;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [N_NORM-1:0] norm_req, emg_req;
    logic [SYS_N-1:0]  sys_oh;
    logic [1:0]        sys_idx;
    logic              sys_any;
    logic [N_DMA-1:0]  dma_oh;
    logic [DIW-1:0]    dma_idx;
    logic              dma_any;
    logic [N_NORM-1:0] emg_oh, nrm_oh;
    logic [NIW-1:0]    emg_idx, nrm_idx;
    logic              emg_any, nrm_any;
    tier_e             tier;

    emg_tier_map #(.N_CH(N_CH), .N_MC(N_MC)) u_map (
        .ch_rx   (ch_rx),
        .ch_tx   (ch_tx),
        .ch_emg  (ch_emg),
        .mc_rx   (mc_rx),
        .mc_tx   (mc_tx),
        .mc_emg  (mc_emg),
        .norm_req(norm_req),
        .emg_req (emg_req)
    );

    emg_prio_pick #(.W(SYS_N)) u_sys (
        .req({req_cmd, req_buserr, req_rst}),
        .oh (sys_oh),
        .idx(sys_idx),
        .any(sys_any)
    );

    emg_prio_pick #(.W(N_DMA)) u_dma (
        .req(dma_req),
        .oh (dma_oh),
        .idx(dma_idx),
        .any(dma_any)
    );

    emg_prio_pick #(.W(N_NORM)) u_emg (
        .req(emg_req),
        .oh (emg_oh),
        .idx(emg_idx),
        .any(emg_any)
    );

    emg_prio_pick #(.W(N_NORM)) u_nrm (
        .req(norm_req),
        .oh (nrm_oh),
        .idx(nrm_idx),
        .any(nrm_any)
    );

    // Tier selection: the DMA slot moves around the emergency tier.
    always_comb begin
        if (sys_any)                   tier = TIER_SYS;
        else if (!dma_alt && dma_any)  tier = TIER_DMA;
        else if (emg_any)              tier = TIER_EMG;
        else if (dma_any)              tier = TIER_DMA;
        else if (nrm_any)              tier = TIER_NORM;
        else                           tier = TIER_NONE;
    end

    always_comb begin
        st_d = '0;
        unique case (tier)
            TIER_SYS: begin
                st_d.gnt[SYS_N-1:0] = sys_oh;
                st_d.idx            = IDXW'(sys_idx);
            end
            TIER_DMA: begin
                st_d.gnt[DMA_BASE +: N_DMA] = dma_oh;
                st_d.idx = IDXW'(DMA_BASE) + IDXW'(dma_idx);
            end
            TIER_EMG: begin
                st_d.gnt[NORM_BASE +: N_NORM] = emg_oh;
                st_d.idx   = IDXW'(NORM_BASE) + IDXW'(emg_idx);
                st_d.emerg = 1'b1;
            end
            TIER_NORM: begin
                st_d.gnt[NORM_BASE +: N_NORM] = nrm_oh;
                st_d.idx = IDXW'(NORM_BASE) + IDXW'(nrm_idx);
            end
            default: ;
        endcase
        st_d.valid = (tier != TIER_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt       = st_q.gnt;
    assign gnt_idx   = st_q.idx;
    assign gnt_valid = st_q.valid;
    assign gnt_emerg = st_q.emerg;

    // ---------------- assertions ----------------
    logic any_port_req;
    assign any_port_req = req_rst | req_buserr | req_cmd | (|dma_req) |
                          (|ch_rx) | (|ch_tx) | (|mc_rx) | (|mc_tx);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_port_req |=> (!gnt_valid && gnt == '0 && !gnt_emerg));

    p_reset_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_rst |=> (gnt[0] && gnt_idx == '0));

    p_buserr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_rst && req_buserr) |=> (gnt[1] && gnt_idx == IDXW'(1)));

    p_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_rst && !req_buserr && req_cmd) |=> gnt[2]);

    p_dma_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_any && !dma_alt && dma_any) |=>
        (!gnt_emerg && gnt_idx >= IDXW'(DMA_BASE) && gnt_idx < IDXW'(NORM_BASE)));

    p_dma_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_any && dma_alt && dma_any && !emg_any) |=>
        (gnt_idx >= IDXW'(DMA_BASE) && gnt_idx < IDXW'(NORM_BASE)));

    p_dma_low_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_any && dma_req[0] && (!dma_alt || !emg_any)) |=> gnt[DMA_BASE]);

    p_emerg_tier_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_any && emg_any && (dma_alt || !dma_any)) |=> gnt_emerg);

    p_flag_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !emg_any |=> !gnt_emerg);

    p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_valid == (gnt != '0)));

endmodule

// File: tb/emg_prio_arb_tb.sv
`timescale 1ns/1ps
module emg_prio_arb_tb;

    localparam int N_CH = 3, N_MC = 2, N_DMA = 4;
    localparam int NSRC = 17, IDXW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_rst = 0, req_buserr = 0, req_cmd = 0, dma_alt = 0;
    logic [N_DMA-1:0]  dma_req = '0;
    logic [N_CH-1:0]   ch_rx = '0, ch_tx = '0, ch_emg = '0;
    logic [N_MC-1:0]   mc_rx = '0, mc_tx = '0, mc_emg = '0;
    logic [NSRC-1:0]   gnt;
    logic [IDXW-1:0]   gnt_idx;
    logic              gnt_valid, gnt_emerg;

    always #2.5 clk = ~clk;

    emg_prio_arb #(.N_CH(N_CH), .N_MC(N_MC), .N_DMA(N_DMA)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_rst(req_rst), .req_buserr(req_buserr), .req_cmd(req_cmd),
        .dma_req(dma_req), .dma_alt(dma_alt),
        .ch_rx(ch_rx), .ch_tx(ch_tx), .ch_emg(ch_emg),
        .mc_rx(mc_rx), .mc_tx(mc_tx), .mc_emg(mc_emg),
        .gnt(gnt), .gnt_idx(gnt_idx), .gnt_valid(gnt_valid), .gnt_emerg(gnt_emerg)
    );

    typedef struct packed {
        logic       rs, be, cm;
        logic [3:0] dma;
        logic       alt;
        logic [2:0] crx, ctx, cem;
        logic [1:0] mrx, mtx, mem;
        logic [4:0] eidx;
        logic       ev, ee;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{0,0,0,4'h0,0,3'b000,3'b000,3'b000,2'b00,2'b00,2'b00, 5'd0, 0,0}, // R1 idle
        '{1,1,1,4'hF,0,3'b111,3'b111,3'b111,2'b11,2'b11,2'b11, 5'd0, 1,0}, // R2
        '{0,1,1,4'hF,0,3'b000,3'b000,3'b000,2'b00,2'b00,2'b00, 5'd1, 1,0}, // R3
        '{0,0,1,4'h1,0,3'b001,3'b000,3'b001,2'b00,2'b00,2'b00, 5'd2, 1,0}, // R4
        '{0,0,0,4'h6,0,3'b001,3'b000,3'b001,2'b00,2'b00,2'b00, 5'd4, 1,0}, // R5
        '{0,0,0,4'h6,1,3'b001,3'b000,3'b001,2'b00,2'b00,2'b00, 5'd7, 1,1}, // R6
        '{0,0,0,4'h8,1,3'b001,3'b000,3'b000,2'b00,2'b00,2'b00, 5'd6, 1,0}, // R6
        '{0,0,0,4'hC,0,3'b000,3'b000,3'b000,2'b00,2'b00,2'b00, 5'd5, 1,0}, // R7
        '{0,0,0,4'h0,0,3'b111,3'b000,3'b000,2'b00,2'b00,2'b00, 5'd7, 1,0}, // R10
        '{0,0,0,4'h0,0,3'b000,3'b001,3'b000,2'b01,2'b00,2'b00, 5'd8, 1,0}, // R10
        '{0,0,0,4'h0,0,3'b000,3'b000,3'b000,2'b10,2'b01,2'b00, 5'd10,1,0}, // R10
        '{0,0,0,4'h0,0,3'b010,3'b000,3'b000,2'b00,2'b10,2'b00, 5'd12,1,0}, // R10
        '{0,0,0,4'h0,0,3'b100,3'b010,3'b000,2'b00,2'b00,2'b00, 5'd14,1,0}, // R10
        '{0,0,0,4'h0,0,3'b000,3'b100,3'b000,2'b00,2'b00,2'b00, 5'd16,1,0}, // R10
        '{0,0,0,4'h0,0,3'b001,3'b100,3'b100,2'b00,2'b00,2'b00, 5'd16,1,1}, // R8
        '{0,0,0,4'h0,0,3'b010,3'b000,3'b010,2'b00,2'b10,2'b10, 5'd12,1,1}, // R9
        '{0,0,0,4'h0,0,3'b010,3'b100,3'b001,2'b00,2'b00,2'b11, 5'd13,1,0}, // R11
        '{0,0,0,4'h0,0,3'b011,3'b010,3'b010,2'b00,2'b00,2'b00, 5'd13,1,1}  // R9
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        {req_rst, req_buserr, req_cmd, dma_alt} = '0;
        dma_req = '0; ch_rx = '0; ch_tx = '0; ch_emg = '0;
        mc_rx = '0; mc_tx = '0; mc_emg = '0;
    endtask

    task automatic check_out(input string req, input logic [4:0] eidx,
                             input logic ev, input logic ee);
        logic [NSRC-1:0] eg;
        eg = ev ? (NSRC'(1) << eidx) : '0;
        chk(req, 32'(gnt_idx), 32'(eidx));
        chk(req, 32'(gnt_valid), 32'(ev));
        chk(req, 32'(gnt_emerg), 32'(ee));
        chk({req, "/R13"}, 32'(gnt), 32'(eg));
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 reset state", 5'd0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {req_rst, req_buserr, req_cmd} = {VEC[v].rs, VEC[v].be, VEC[v].cm};
            dma_req = VEC[v].dma; dma_alt = VEC[v].alt;
            ch_rx = VEC[v].crx; ch_tx = VEC[v].ctx; ch_emg = VEC[v].cem;
            mc_rx = VEC[v].mrx; mc_tx = VEC[v].mtx; mc_emg = VEC[v].mem;
            @(posedge clk); #1;
            check_out($sformatf("vector %0d", v), VEC[v].eidx, VEC[v].ev, VEC[v].ee);
        end

        // R12: one-cycle latency and no hold after the request drops.
        @(negedge clk) clear_inputs();
        @(posedge clk); #1;
        chk("R1 idle after traffic", 32'(gnt_valid), 32'd0);
        @(negedge clk) req_cmd = 1'b1;
        #1;
        chk("R12 no grant before edge", 32'(gnt_valid), 32'd0);
        @(posedge clk); #1;
        chk("R12 grant one cycle later", 32'(gnt_idx), 32'd2);
        @(negedge clk) begin req_cmd = 1'b0; mc_tx = 2'b01; end
        @(posedge clk); #1;
        chk("R12 grant follows new request", 32'(gnt_idx), 32'd11);
        @(negedge clk) mc_tx = 2'b00;
        @(posedge clk); #1;
        chk("R12 grant released", 32'(gnt_valid), 32'd0);

        // R11: flag alone on every channel, no traffic.
        @(negedge clk) begin ch_emg = '1; mc_emg = '1; end
        @(posedge clk); #1;
        check_out("R11 flags without requests", 5'd0, 1'b0, 1'b0);

        // R1: reset mid-run clears held grant.
        @(negedge clk) begin clear_inputs(); dma_req = 4'b0010; end
        @(posedge clk); #1;
        chk("R7 single DMA channel", 32'(gnt_idx), 32'd4);
        @(negedge clk) rst_n = 1'b0;
        #1;
        check_out("R1 async reset", 5'd0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R12 rearbitrates after reset", 32'(gnt_idx), 32'd4);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule